// File: doc/BRIEF.md
# Comparator Event Interrupt Unit

This block watches the digital output of an analog comparator and raises a sticky interrupt flag when a chosen kind of transition occurs. The input comes straight from the comparator, so it first passes through a two-stage synchronizer. It is then compared with its value from the previous cycle to find rising and falling transitions. A 2-bit event-select field picks the event that sets the flag: any change, only falling, or only rising. One code of this field is unused and never sets the flag.

Software drives the block through a single control word. The word holds the event select, a capture-routing option, a local interrupt enable and the flag. The flag clears when software writes a one to its bit. It also clears when the core pulses an acknowledge while servicing the interrupt. The interrupt request leaves the block only when the flag, the local enable and the chip-wide interrupt enable are all set. When the routing option is set, the synchronized comparator level drives the capture-trigger output in place of the ordinary capture pin.

Top module: `cmp_evt_irq`

## Requirements
- R1: After a synchronous reset (rst_n low at a clock edge), ctl_rdata[4:0] reads 0 (event select 00, routing off, enable off, flag clear) and irq_req is 0.
- R2: A change on cmp_raw appears in ctl_rdata[5] (the synchronized level) two clock edges later. A qualifying event sets the flag (ctl_rdata[4]) on the third edge.
- R3: With event select ctl_rdata[1:0] = 00, both a rising and a falling transition of the synchronized level set the flag.
- R4: With event select 10, a falling transition sets the flag and a rising transition does not.
- R5: With event select 11, a rising transition sets the flag and a falling transition does not.
- R6: With event select 01 (unused code), no transition ever sets the flag.
- R7: irq_req is 1 exactly when the flag, the local enable (ctl_rdata[3]) and global_ie are all 1.
- R8: A control write (ctl_we) with ctl_wdata[4] = 1 clears the flag. A write with ctl_wdata[4] = 0 leaves the flag unchanged. The same write loads ctl_wdata[1:0] as event select, ctl_wdata[2] as routing and ctl_wdata[3] as enable.
- R9: A one-cycle irq_ack pulse clears the flag.
- R10: If an event occurs in the same cycle as a flag-clearing write or an acknowledge, the flag ends up set.
- R11: With routing (ctl_rdata[2]) set, cap_trig follows the synchronized comparator level. With routing clear, cap_trig follows cap_pin.
- R12: Changing the event select while the synchronized level is steady does not set the flag. Clearing the local enable before such a change keeps irq_req low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmp_raw | input | 1 | Asynchronous comparator output |
| cap_pin | input | 1 | Ordinary capture input pin |
| global_ie | input | 1 | Chip-wide interrupt enable |
| irq_ack | input | 1 | One-cycle interrupt acknowledge |
| ctl_we | input | 1 | Control word write strobe |
| ctl_wdata | input | 5 | Write data: [1:0] event select, [2] routing, [3] enable, [4] write one to clear flag |
| ctl_rdata | output | 6 | Read data: [1:0] event select, [2] routing, [3] enable, [4] flag, [5] synchronized level |
| irq_req | output | 1 | Interrupt request to the core |
| cap_trig | output | 1 | Capture trigger output |

## Verification
On every cycle the assertions check several rules. A detected event always sets the flag, and the unused select code never does. An event under the rising or falling select matches the matching transition of the synchronized level. Clearing writes and acknowledges without a coinciding event leave the flag clear. The request never appears while the global enable is low, and the routed capture output tracks the synchronized level. Only the bench's scenarios show the exact synchronizer latency and the full matrix of select codes against transition directions. They also show that a select change on a steady input stays silent, and how colliding set and clear operations resolve.

// File: rtl/cmp_evt_pkg.sv
// Package: shared types and control-word field positions for the
// comparator event interrupt unit. Assumes a 5-bit write word and a
// 6-bit read word.
package cmp_evt_pkg;
    typedef enum logic [1:0] {
        SEL_ANY  = 2'b00,
        SEL_NONE = 2'b01,
        SEL_FALL = 2'b10,
        SEL_RISE = 2'b11
    } evt_sel_e;

    localparam int SEL_W     = 2;
    localparam int ROUTE_POS = 2;
    localparam int EN_POS    = 3;
    localparam int FLAG_POS  = 4;
    localparam int LVL_POS   = 5;
    localparam int WR_W      = 5;
    localparam int RD_W      = 6;
endpackage

// File: rtl/cmp_evt_sync.sv
// Synchronizer: a chain of STAGES flops that brings the asynchronous
// comparator output into the clock domain. Assumes STAGES >= 2.
module cmp_evt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Shift the level one flop further down the chain
            always_ff @(posedge clk) begin
                if (!rst_n) chain[i] <= 1'b0;
                else if (i == 0) chain[i] <= d_async;
                else chain[i] <= chain[(i == 0) ? 0 : i-1];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/cmp_evt_edge.sv
// Edge qualifier: keeps last cycle's synchronized level and reports an
// event for the selected transition kind. The unused select code never
// reports an event. Assumes lvl is already synchronous.
module cmp_evt_edge
    import cmp_evt_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     lvl,
    input  evt_sel_e sel,
    output logic     evt
);
    logic lvl_d;
    logic up;
    logic down;

    // Hold the previous level for comparison
    always_ff @(posedge clk) begin
        if (!rst_n) lvl_d <= 1'b0;
        else        lvl_d <= lvl;
    end

    assign up   = lvl & ~lvl_d;
    assign down = ~lvl & lvl_d;

    // Select which transition counts as an event
    always_comb begin
        case (sel)
            SEL_ANY:  evt = up | down;
            SEL_FALL: evt = down;
            SEL_RISE: evt = up;
            default:  evt = 1'b0;
        endcase
    end
endmodule

// File: rtl/cmp_evt_ctrl.sv
// Control word and flag: holds the select, routing and enable fields.
// The flag is set by an event and cleared by write-one or acknowledge.
// A set wins over a clear in the same cycle. Assumes single-cycle
// write and acknowledge strobes.
module cmp_evt_ctrl
    import cmp_evt_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            we,
    input  logic [WR_W-1:0] wdata,
    input  logic            evt,
    input  logic            ack,
    input  logic            gie,
    output evt_sel_e        sel,
    output logic            route,
    output logic            en,
    output logic            flag,
    output logic            req
);
    logic clr;

    assign clr = (we && wdata[FLAG_POS]) || ack;

    // Load the configuration fields on a write
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel   <= SEL_ANY;
            route <= 1'b0;
            en    <= 1'b0;
        end else if (we) begin
            sel   <= evt_sel_e'(wdata[SEL_W-1:0]);
            route <= wdata[ROUTE_POS];
            en    <= wdata[EN_POS];
        end
    end

    // Sticky flag with set priority over clear
    always_ff @(posedge clk) begin
        if (!rst_n)   flag <= 1'b0;
        else if (evt) flag <= 1'b1;
        else if (clr) flag <= 1'b0;
    end

    assign req = flag & en & gie;
endmodule

// File: rtl/cmp_evt_irq.sv
// Top: comparator event interrupt unit. It synchronizes the comparator,
// qualifies transitions, keeps the flag and control word, and muxes the
// capture trigger. Assumes cap_pin is already synchronous.
module cmp_evt_irq
    import cmp_evt_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cmp_raw,
    input  logic            cap_pin,
    input  logic            global_ie,
    input  logic            irq_ack,
    input  logic            ctl_we,
    input  logic [WR_W-1:0] ctl_wdata,
    output logic [RD_W-1:0] ctl_rdata,
    output logic            irq_req,
    output logic            cap_trig
);
    logic     lvl;
    logic     evt;
    evt_sel_e sel;
    logic     route;
    logic     en;
    logic     flag;

    cmp_evt_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_async(cmp_raw), .q_sync(lvl)
    );

    cmp_evt_edge u_edge (
        .clk(clk), .rst_n(rst_n), .lvl(lvl), .sel(sel), .evt(evt)
    );

    cmp_evt_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .we(ctl_we), .wdata(ctl_wdata),
        .evt(evt), .ack(irq_ack), .gie(global_ie),
        .sel(sel), .route(route), .en(en), .flag(flag), .req(irq_req)
    );

    assign ctl_rdata = {lvl, flag, en, route, sel};
    assign cap_trig  = route ? lvl : cap_pin;
endmodule

// File: rtl/cmp_evt_irq_chk.sv
// Checker: properties over the unit's ports and internal nets, bound to
// every instance of cmp_evt_irq.
module cmp_evt_irq_chk
    import cmp_evt_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            lvl,
    input logic            evt,
    input logic            flag,
    input logic [1:0]      sel,
    input logic            route,
    input logic            ctl_we,
    input logic [WR_W-1:0] ctl_wdata,
    input logic            irq_ack,
    input logic            global_ie,
    input logic            irq_req,
    input logic            cap_trig
);
    // R10
    evt_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt |=> flag);

    // R6
    unused_sel_silent_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b01 && !flag) |=> !flag);

    // R5
    rise_sel_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b11 && evt) |-> $rose(lvl));

    // R4
    fall_sel_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sel == 2'b10 && evt) |-> $fell(lvl));

    // R8
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_we && ctl_wdata[FLAG_POS] && !evt) |=> !flag);

    // R9
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && !evt) |=> !flag);

    // R7
    req_needs_gie_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req |-> (global_ie && flag));

    // R11
    route_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
        route |-> (cap_trig == lvl));
endmodule

bind cmp_evt_irq cmp_evt_irq_chk u_chk (
    .clk(clk), .rst_n(rst_n), .lvl(lvl), .evt(evt), .flag(flag),
    .sel(sel), .route(route), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
    .irq_ack(irq_ack), .global_ie(global_ie), .irq_req(irq_req),
    .cap_trig(cap_trig)
);

// File: tb/cmp_evt_irq_test.sv
module cmp_evt_irq_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cmp_raw = 1'b0;
    logic       cap_pin = 1'b0;
    logic       global_ie = 1'b0;
    logic       irq_ack = 1'b0;
    logic       ctl_we = 1'b0;
    logic [4:0] ctl_wdata = 5'd0;
    logic [5:0] ctl_rdata;
    logic       irq_req;
    logic       cap_trig;

    int checks = 0;
    int failures = 0;

    always #5 clk = ~clk;

    cmp_evt_irq uut (
        .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw), .cap_pin(cap_pin),
        .global_ie(global_ie), .irq_ack(irq_ack), .ctl_we(ctl_we),
        .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .irq_req(irq_req),
        .cap_trig(cap_trig)
    );

    // Vector: {select[1:0], start level, end level, expected flag}
    localparam logic [4:0] VEC [8] = '{
        {2'b00, 1'b0, 1'b1, 1'b1}, // R3
        {2'b00, 1'b1, 1'b0, 1'b1}, // R3
        {2'b10, 1'b1, 1'b0, 1'b1}, // R4
        {2'b10, 1'b0, 1'b1, 1'b0}, // R4
        {2'b11, 1'b0, 1'b1, 1'b1}, // R5
        {2'b11, 1'b1, 1'b0, 1'b0}, // R5
        {2'b01, 1'b0, 1'b1, 1'b0}, // R6
        {2'b01, 1'b1, 1'b0, 1'b0}  // R6
    };

    task automatic check(input logic [5:0] act, input logic [5:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] d);
        @(negedge clk);
        ctl_we = 1'b1;
        ctl_wdata = d;
        @(negedge clk);
        ctl_we = 1'b0;
        ctl_wdata = 5'd0;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    function automatic string sel_tag(input logic [1:0] s);
        case (s)
            2'b00:   return "R3";
            2'b10:   return "R4";
            2'b11:   return "R5";
            default: return "R6";
        endcase
    endfunction

    initial begin
        repeat (20000) @(posedge clk);
        failures++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        wait_n(3);
        // R1 reset state
        check({irq_req, ctl_rdata[4:0]}, 6'd0, "R1");
        @(negedge clk) rst_n = 1'b1;
        global_ie = 1'b1;

        // Table walk over select codes and directions
        for (int i = 0; i < 8; i++) begin
            logic [1:0] s;
            s = VEC[i][4:3];
            wr({1'b0, 1'b1, 1'b0, s});
            cmp_raw = VEC[i][2];
            wait_n(4);
            wr({1'b1, 1'b1, 1'b0, s});
            check({5'd0, ctl_rdata[4]}, 6'd0, sel_tag(s));
            cmp_raw = VEC[i][1];
            wait_n(4);
            check({4'd0, irq_req, ctl_rdata[4]}, {4'd0, VEC[i][0], VEC[i][0]}, sel_tag(s));
        end

        // R2 exact latency: level after two edges, flag after three
        wr(5'b11000);
        cmp_raw = ~ctl_rdata[5];
        begin
            logic nl;
            nl = cmp_raw;
            wait_n(1);
            check({4'd0, ctl_rdata[5], ctl_rdata[4]}, {4'd0, ~nl, 1'b0}, "R2");
            wait_n(1);
            check({4'd0, ctl_rdata[5], ctl_rdata[4]}, {4'd0, nl, 1'b0}, "R2");
            wait_n(1);
            check({5'd0, ctl_rdata[4]}, 6'd1, "R2");
        end

        // R7 request gating with flag set
        global_ie = 1'b0;
        wait_n(1);
        check({5'd0, irq_req}, 6'd0, "R7 gie low");
        global_ie = 1'b1;
        wr(5'b00000);
        check({4'd0, irq_req, ctl_rdata[4]}, 6'b01, "R7 enable low");

        // R8 write with flag bit zero keeps flag, loads fields
        wr(5'b01111);
        check(ctl_rdata, {cmp_raw, 5'b11111}, "R8 keep and load");
        wr(5'b11000);
        check({5'd0, ctl_rdata[4]}, 6'd0, "R8 clear");

        // R9 acknowledge pulse clears
        cmp_raw = ~cmp_raw;
        wait_n(4);
        @(negedge clk) irq_ack = 1'b1;
        @(negedge clk) irq_ack = 1'b0;
        check({5'd0, ctl_rdata[4]}, 6'd0, "R9");

        // R10 clearing write coincides with event
        cmp_raw = ~cmp_raw;
        wait_n(2);
        ctl_we = 1'b1;
        ctl_wdata = 5'b11000;
        @(negedge clk);
        ctl_we = 1'b0;
        ctl_wdata = 5'd0;
        check({5'd0, ctl_rdata[4]}, 6'd1, "R10 write");
        wr(5'b11000);
        // R10 acknowledge coincides with event
        cmp_raw = ~cmp_raw;
        wait_n(2);
        irq_ack = 1'b1;
        @(negedge clk);
        irq_ack = 1'b0;
        check({5'd0, ctl_rdata[4]}, 6'd1, "R10 ack");
        wr(5'b11000);

        // R11 capture routing
        cap_pin = 1'b1;
        cmp_raw = 1'b0;
        wait_n(3);
        check({5'd0, cap_trig}, 6'd1, "R11 pin");
        wr(5'b11100);
        check({5'd0, cap_trig}, 6'd0, "R11 routed");
        cmp_raw = 1'b1;
        wait_n(3);
        check({5'd0, cap_trig}, 6'd1, "R11 routed follow");

        // R12 select changes on a steady level
        wr(5'b11011);
        wr(5'b01010);
        wr(5'b01000);
        wr(5'b01001);
        check({4'd0, irq_req, ctl_rdata[4]}, 6'd0, "R12 steady");
        wr(5'b00011);
        wr(5'b00010);
        check({5'd0, irq_req}, 6'd0, "R12 disabled");

        $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule